// File: doc/BRIEF.md
# Flag-Conditional Branch Unit

This block resolves the control-flow decision for the jump family of an 8-bit accumulator processor with a 16-bit address space. It takes one decoded instruction at a time: the 6-bit opcode, the 2 prefix bits, the two address bytes that follow the opcode, the registered ALU flags, the accumulator and the address of the instruction byte. It returns whether control transfers and the program counter value to continue from.

Three conditional opcodes test one flag each: carry, zero or equal. Prefix bit 0 turns any of them into its branch-if-clear form. A taken conditional branch resumes at the assembled target plus one. A branch that is not taken skips its two address bytes. The unconditional jump always transfers, using the accumulator as the new program counter. Every other opcode is passed through as not taken, with the counter stepping over the single instruction byte.

The instruction arrives on a valid/ready input and the decision leaves on a valid/ready output held in one register stage. An instruction is taken in on a rising edge where `in_valid` and `in_ready` are both high. Its result shows one cycle later with `out_valid`. While the result waits with `out_ready` low, the output holds and `in_ready` stays low, so no new instruction is accepted. When `out_ready` is high, a new instruction can be accepted on the same edge that the waiting result is consumed.

Top module: `cond_branch_unit`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1. A reset asserted while a result is waiting clears `out_valid`.
- R2: Opcode 0x28 tests the carry flag, 0x29 the zero flag and 0x2A the equal flag. With prefix bit 0 clear, the branch is taken exactly when the tested flag is 1. The two flags that are not tested have no effect.
- R3: With prefix bit 0 set, a conditional opcode is taken exactly when its tested flag is 0.
- R4: A taken conditional branch gives `out_next_pc` = {addr_hi, addr_lo} + 1 modulo 2^16. The high byte is `addr_hi`, and a target of 0xFFFF gives 0x0000.
- R5: A conditional branch that is not taken gives `out_next_pc` = pc + 3 modulo 2^16, with `out_taken` = 0.
- R6: Opcode 0x27 always gives `out_taken` = 1 and `out_next_pc` = the accumulator, zero-extended to 16 bits. Flags, prefix and address bytes do not affect the result.
- R7: Any opcode other than 0x27 to 0x2A gives `out_taken` = 0 and `out_next_pc` = pc + 1 modulo 2^16.
- R8: Prefix bit 1 has no effect on the result.
- R9: An instruction is accepted on an edge with `in_valid` and `in_ready` high, and its result is presented with `out_valid` = 1 after that edge. `in_ready` is 0 while a result waits with `out_ready` low. A result is dropped from the output after an edge with `out_ready` high and no new acceptance.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_taken` and `out_next_pc` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction fields are valid |
| in_ready | output | 1 | Unit can accept an instruction |
| opcode | input | 6 | Opcode field of the instruction byte |
| prefix | input | 2 | Prefix bits; bit 0 inverts the condition |
| addr_lo | input | 8 | First address byte (target low byte) |
| addr_hi | input | 8 | Second address byte (target high byte) |
| acc | input | 8 | Accumulator value |
| pc | input | 16 | Address of the instruction byte |
| flag_carry | input | 1 | Registered carry flag |
| flag_zero | input | 1 | Registered zero flag |
| flag_equal | input | 1 | Registered equal flag |
| out_valid | output | 1 | Decision is valid |
| out_ready | input | 1 | Consumer accepts the decision |
| out_taken | output | 1 | Control transfers |
| out_next_pc | output | 16 | Program counter to continue from |

## Verification
The properties assume the instruction fields and flags are settled whenever `in_valid` is high at a rising edge. They also assume that the flag inputs already hold the registered values from an earlier ALU operation, so the result depends only on the sampled values. The stimulus changes every input only at falling edges, and it lowers `in_valid` between instructions except in the stall sequence. There, an instruction is held on the input deliberately, to show that it is not taken in until the waiting result is consumed.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  // Opcodes whose value the decoder depends on
  localparam logic [5:0] OPC_JUMP   = 6'h27;
  localparam logic [5:0] OPC_BR_CY  = 6'h28;
  localparam logic [5:0] OPC_BR_ZR  = 6'h29;
  localparam logic [5:0] OPC_BR_EQ  = 6'h2A;

  // Prefix bit that turns a test into its branch-if-clear form
  localparam int NEG_BIT = 0;

  typedef enum logic [1:0] {
    KIND_PASS = 2'd0,
    KIND_JUMP = 2'd1,
    KIND_COND = 2'd2
  } br_kind_e;

endpackage

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             neg,
  input  logic             flag_carry,
  input  logic             flag_zero,
  input  logic             flag_equal,
  output br_kind_e         kind,
  output logic             taken
);

  logic sel_flag;

  always_comb begin
    kind     = KIND_PASS;
    sel_flag = 1'b0;
    unique case (opcode)
      OPC_JUMP:  kind = KIND_JUMP;
      OPC_BR_CY: begin kind = KIND_COND; sel_flag = flag_carry; end
      OPC_BR_ZR: begin kind = KIND_COND; sel_flag = flag_zero;  end
      OPC_BR_EQ: begin kind = KIND_COND; sel_flag = flag_equal; end
      default:   kind = KIND_PASS;
    endcase
  end

  always_comb begin
    unique case (kind)
      KIND_JUMP: taken = 1'b1;
      KIND_COND: taken = sel_flag ^ neg;
      default:   taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/cbu_pc_calc.sv
module cbu_pc_calc
  import cbu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ACC_W  = 8
) (
  input  br_kind_e          kind,
  input  logic              taken,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  input  logic [ACC_W-1:0]  acc,
  output logic [ADDR_W-1:0] next_pc
);

  localparam logic [ADDR_W-1:0] STEP_ONE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_BRLEN = ADDR_W'(3);

  logic [ADDR_W-1:0] acc_ext;

  generate
    if (ACC_W >= ADDR_W) begin : g_acc_trunc
      assign acc_ext = acc[ADDR_W-1:0];
    end else begin : g_acc_zext
      assign acc_ext = {{(ADDR_W-ACC_W){1'b0}}, acc};
    end
  endgenerate

  logic [ADDR_W-1:0] tgt_plus;
  logic [ADDR_W-1:0] skip_pc;
  logic [ADDR_W-1:0] seq_pc;

  assign tgt_plus = target + STEP_ONE;
  assign skip_pc  = pc + STEP_BRLEN;
  assign seq_pc   = pc + STEP_ONE;

  always_comb begin
    unique case (kind)
      KIND_JUMP: next_pc = acc_ext;
      KIND_COND: next_pc = taken ? tgt_plus : skip_pc;
      default:   next_pc = seq_pc;
    endcase
  end

endmodule

// File: rtl/cbu_out_stage.sv
module cbu_out_stage #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  assign s_ready = !vld_q || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (s_ready) begin
      vld_q <= s_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s_valid && s_ready) begin
      dat_q <= s_data;
    end
  end

  assign m_valid = vld_q;
  assign m_data  = dat_q;

endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OPC_W  = 6,
  parameter int PFX_W  = 2,
  parameter int ACC_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OPC_W-1:0]    opcode,
  input  logic [PFX_W-1:0]    prefix,
  input  logic [BYTE_W-1:0]   addr_lo,
  input  logic [BYTE_W-1:0]   addr_hi,
  input  logic [ACC_W-1:0]    acc,
  input  logic [2*BYTE_W-1:0] pc,
  input  logic                flag_carry,
  input  logic                flag_zero,
  input  logic                flag_equal,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_taken,
  output logic [2*BYTE_W-1:0] out_next_pc
);

  localparam int ADDR_W = 2 * BYTE_W;
  localparam int RES_W  = ADDR_W + 1;

  logic              unused_pfx;
  logic [ADDR_W-1:0] target;
  br_kind_e          kind;
  logic              taken;
  logic [ADDR_W-1:0] next_pc;
  logic [RES_W-1:0]  res_d;
  logic [RES_W-1:0]  res_q;

  assign unused_pfx = ^prefix;
  assign target     = {addr_hi, addr_lo};

  cbu_cond_eval #(.OPC_W(OPC_W)) u_eval (
    .opcode     (opcode),
    .neg        (prefix[NEG_BIT]),
    .flag_carry (flag_carry),
    .flag_zero  (flag_zero),
    .flag_equal (flag_equal),
    .kind       (kind),
    .taken      (taken)
  );

  cbu_pc_calc #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_calc (
    .kind    (kind),
    .taken   (taken),
    .pc      (pc),
    .target  (target),
    .acc     (acc),
    .next_pc (next_pc)
  );

  assign res_d = {taken, next_pc};

  cbu_out_stage #(.W(RES_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (res_d),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (res_q)
  );

  assign out_taken   = res_q[RES_W-1];
  assign out_next_pc = res_q[ADDR_W-1:0];

endmodule

// File: rtl/cbu_chk.sv
module cbu_chk #(
  parameter int BYTE_W = 8,
  parameter int OPC_W  = 6,
  parameter int PFX_W  = 2,
  parameter int ACC_W  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [OPC_W-1:0]    opcode,
  input logic [PFX_W-1:0]    prefix,
  input logic [BYTE_W-1:0]   addr_lo,
  input logic [BYTE_W-1:0]   addr_hi,
  input logic [ACC_W-1:0]    acc,
  input logic [2*BYTE_W-1:0] pc,
  input logic                flag_carry,
  input logic                out_valid,
  input logic                out_ready,
  input logic                out_taken,
  input logic [2*BYTE_W-1:0] out_next_pc
);

  localparam int ADDR_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] K1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] K3 = ADDR_W'(3);

  logic              fire;
  logic              is_cond;
  logic              is_jump;
  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W-1:0] acc_w;

  assign fire    = in_valid && in_ready;
  assign is_jump = (opcode == OPC_W'(6'h27));
  assign is_cond = (opcode == OPC_W'(6'h28)) || (opcode == OPC_W'(6'h29)) ||
                   (opcode == OPC_W'(6'h2A));
  assign tgt     = {addr_hi, addr_lo};
  assign acc_w   = ADDR_W'(acc);

  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_taken) && $stable(out_next_pc)));

  // R3
  carry_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && opcode == OPC_W'(6'h28)) |=> (out_taken == ($past(flag_carry) ^ $past(prefix[0]))));

  // R4
  taken_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_cond) |=> (!out_taken || out_next_pc == $past(tgt) + K1));

  // R5
  skip_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_cond) |=> (out_taken || out_next_pc == $past(pc) + K3));

  // R6
  jump_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_jump) |=> (out_taken && out_next_pc == $past(acc_w)));

  // R7
  pass_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_jump && !is_cond) |=> (!out_taken && out_next_pc == $past(pc) + K1));

endmodule

bind cond_branch_unit cbu_chk #(
  .BYTE_W(BYTE_W), .OPC_W(OPC_W), .PFX_W(PFX_W), .ACC_W(ACC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .opcode      (opcode),
  .prefix      (prefix),
  .addr_lo     (addr_lo),
  .addr_hi     (addr_hi),
  .acc         (acc),
  .pc          (pc),
  .flag_carry  (flag_carry),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_taken   (out_taken),
  .out_next_pc (out_next_pc)
);

// File: tb/cond_branch_unit_tb.sv
module cond_branch_unit_tb;

  typedef struct packed {
    logic [5:0]  opc;
    logic [1:0]  pre;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic        c;
    logic        z;
    logic        e;
    logic [15:0] pc;
    logic [7:0]  acc;
    logic        tk;
    logic [15:0] npc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    // R2 carry set, taken
    '{6'h28, 2'b00, 8'h34, 8'h12, 1'b1, 1'b0, 1'b0, 16'h0100, 8'h00, 1'b1, 16'h1235, 4'd2},
    // R5 carry clear, falls through
    '{6'h28, 2'b00, 8'h34, 8'h12, 1'b0, 1'b1, 1'b1, 16'h0100, 8'h00, 1'b0, 16'h0103, 4'd5},
    // R3 inverted carry, clear -> taken
    '{6'h28, 2'b01, 8'h34, 8'h12, 1'b0, 1'b0, 1'b0, 16'h0100, 8'h00, 1'b1, 16'h1235, 4'd3},
    // R3 inverted carry, set -> not taken
    '{6'h28, 2'b01, 8'h34, 8'h12, 1'b1, 1'b1, 1'b1, 16'h0100, 8'h00, 1'b0, 16'h0103, 4'd3},
    // R2 zero set, taken
    '{6'h29, 2'b00, 8'hCD, 8'hAB, 1'b0, 1'b1, 1'b0, 16'h0500, 8'h00, 1'b1, 16'hABCE, 4'd2},
    // R2 zero clear, other flags set -> not taken
    '{6'h29, 2'b00, 8'hCD, 8'hAB, 1'b1, 1'b0, 1'b1, 16'h2000, 8'h00, 1'b0, 16'h2003, 4'd2},
    // R3 inverted zero, clear -> taken
    '{6'h29, 2'b01, 8'hCD, 8'hAB, 1'b1, 1'b0, 1'b1, 16'h2000, 8'h00, 1'b1, 16'hABCE, 4'd3},
    // R4 equal taken, carry into high byte
    '{6'h2A, 2'b00, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0700, 8'h00, 1'b1, 16'h0100, 4'd4},
    // R5 inverted equal not taken, pc wraps
    '{6'h2A, 2'b01, 8'h00, 8'h10, 1'b0, 1'b0, 1'b1, 16'hFFFE, 8'h00, 1'b0, 16'h0001, 4'd5},
    // R4 target 0xFFFF wraps to 0
    '{6'h2A, 2'b00, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 16'h0000, 8'h00, 1'b1, 16'h0000, 4'd4},
    // R2 equal clear, carry and zero set -> not taken
    '{6'h2A, 2'b00, 8'h11, 8'h22, 1'b1, 1'b1, 1'b0, 16'h0040, 8'h00, 1'b0, 16'h0043, 4'd2},
    // R6 jump, prefix set, flags clear
    '{6'h27, 2'b11, 8'h34, 8'h12, 1'b0, 1'b0, 1'b0, 16'h0900, 8'h5A, 1'b1, 16'h005A, 4'd6},
    // R6 jump, flags set
    '{6'h27, 2'b00, 8'hEE, 8'hEE, 1'b1, 1'b1, 1'b1, 16'h0900, 8'hFF, 1'b1, 16'h00FF, 4'd6},
    // R7 other opcode with flags set
    '{6'h3E, 2'b01, 8'h34, 8'h12, 1'b1, 1'b1, 1'b1, 16'h0040, 8'h77, 1'b0, 16'h0041, 4'd7},
    // R7 pc wraps
    '{6'h00, 2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 16'hFFFF, 8'h00, 1'b0, 16'h0000, 4'd7},
    // R7 neighbours of the branch range
    '{6'h26, 2'b00, 8'h34, 8'h12, 1'b1, 1'b1, 1'b1, 16'h0300, 8'h00, 1'b0, 16'h0301, 4'd7},
    '{6'h2B, 2'b00, 8'h34, 8'h12, 1'b1, 1'b1, 1'b1, 16'h0300, 8'h00, 1'b0, 16'h0301, 4'd7},
    // R8 prefix bit 1 alone does not invert
    '{6'h28, 2'b10, 8'h10, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0200, 8'h00, 1'b1, 16'h0011, 4'd8},
    // R8 both prefix bits behave as inverted only
    '{6'h29, 2'b11, 8'h10, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0300, 8'h00, 1'b0, 16'h0303, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  opcode = '0;
  logic [1:0]  prefix = '0;
  logic [7:0]  addr_lo = '0;
  logic [7:0]  addr_hi = '0;
  logic [7:0]  acc = '0;
  logic [15:0] pc = '0;
  logic        flag_carry = 1'b0;
  logic        flag_zero = 1'b0;
  logic        flag_equal = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_taken;
  logic [15:0] out_next_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cond_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opcode(opcode), .prefix(prefix), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .acc(acc), .pc(pc), .flag_carry(flag_carry), .flag_zero(flag_zero),
    .flag_equal(flag_equal), .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_next_pc(out_next_pc)
  );

  task automatic check_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_pc(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    opcode = v.opc; prefix = v.pre; addr_lo = v.lo; addr_hi = v.hi;
    flag_carry = v.c; flag_zero = v.z; flag_equal = v.e;
    pc = v.pc; acc = v.acc;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    @(negedge clk);
    check_bit("R1 out_valid in reset", out_valid, 1'b0);
    check_bit("R1 in_ready in reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 out_valid after reset", out_valid, 1'b0);
    check_bit("R1 in_ready after reset", in_ready, 1'b1);

    // Table of vectors, one instruction per handshake
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      in_valid = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_bit($sformatf("R9 valid vec %0d", i), out_valid, 1'b1);
      check_bit($sformatf("R%0d taken vec %0d", VEC[i].req, i), out_taken, VEC[i].tk);
      check_pc($sformatf("R%0d next_pc vec %0d", VEC[i].req, i), out_next_pc, VEC[i].npc);
    end

    // R9 result drains when consumed and nothing new arrives
    @(negedge clk);
    check_bit("R9 drained", out_valid, 1'b0);

    // R10 back-pressure: hold result A, keep B waiting on the input
    drive(VEC[0]);
    in_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    drive(VEC[1]);
    check_bit("R9 in_ready low while stalled", in_ready, 1'b0);
    check_bit("R10 valid held", out_valid, 1'b1);
    check_pc("R10 A result", out_next_pc, 16'h1235);
    @(negedge clk);
    @(negedge clk);
    check_bit("R10 valid still held", out_valid, 1'b1);
    check_bit("R10 taken held", out_taken, 1'b1);
    check_pc("R10 next_pc held", out_next_pc, 16'h1235);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R9 B accepted on consume edge", out_valid, 1'b1);
    check_bit("R9 B taken", out_taken, 1'b0);
    check_pc("R9 B next_pc", out_next_pc, 16'h0103);
    @(negedge clk);
    check_bit("R9 drained after B", out_valid, 1'b0);

    // R1 reset while a result waits
    drive(VEC[4]);
    in_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R1 result waiting", out_valid, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check_bit("R1 reset clears waiting result", out_valid, 1'b0);
    check_bit("R1 in_ready in second reset", in_ready, 1'b1);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    finish_up();
  end

endmodule